// File: doc/BRIEF.md
# Phased Multi-Lane SPI Transfer Sequencer

This block is the master side of a serial flash style link. One accepted request becomes one transaction, framed by a single low period of chip select. The transaction is split into four phases that always run in the same order: an opcode phase, an address phase, a wait (dummy) phase and a payload phase. Each of the first three phases is sized by its own frame count. The payload phase covers whatever remains of the total frame count. Frames are `FRAME_W` bits wide, 8 by default. They are sent least significant bit first and spread over one, two or four lanes.

A lane-width input picks the wide width, dual or quad. A mode input decides which phases actually use that width. The other phases stay on lane 0. The width for a frame is fixed when the frame starts, so a change of width always falls on a frame boundary. Outgoing frames are taken from a valid/ready source. If no frame is offered, the sequencer holds the serial clock low with chip select still active. In the read direction, payload frames come back through a one-cycle valid strobe.

The controller has six states:
- IDLE: chip select is high.
- LOAD: at a frame boundary, the phase and width for the next frame are chosen and the outgoing byte is fetched.
- LOW: the serial clock is low for half a period.
- HIGH: the serial clock is high for half a period.
- TAIL: the last half period after the final falling edge.
- DONE: one cycle with chip select released and the done strobe high.

The transitions are:
- IDLE→LOAD when a start request is accepted.
- LOAD→LOW once the frame has what it needs.
- LOW→HIGH after each half period.
- HIGH→LOW within a frame.
- HIGH→LOAD between frames.
- HIGH→TAIL after the last frame.
- TAIL→DONE.
- DONE→IDLE.

Top module: `spi_phase_seq`

## Requirements
- R1: After reset, and whenever idle, `cs_n` is 1, `sck` is 0, `dq_oe` is 0, and `busy` and `done` are 0.
- R2: Frames run in the order opcode, address, dummy, payload, with counts `cmd_frames`, `addr_frames`, `dummy_frames`, and the payload taking the rest of `total_frames`. `cs_n` stays low with no break from the first frame to the end.
- R3: With `mode` = 0, every phase uses the wide width.
- R4: With `mode` = 1, the opcode frames use lane 0 only, and the address, dummy and payload frames use the wide width.
- R5: With `mode` = 2 or 3, only the payload frames use the wide width. All other frames use lane 0 only.
- R6: In quad width (`lane_width` = 2 or 3), a frame takes 2 clocks. Clock k drives bits 4k..4k+3 on DQ0..DQ3. The clock idles low, outputs change after a falling edge, and values are meant to be sampled on the rising edge.
- R7: In dual width (`lane_width` = 1), a frame takes 4 clocks. Clock k drives bit 2k on DQ0 and bit 2k+1 on DQ1, with `dq_oe` = 0011.
- R8: With `lane_width` = 0, every frame in every mode uses lane 0 only: 8 clocks, bit k on DQ0, `dq_oe` = 0001.
- R9: A phase whose count is zero takes no frames, and the next phase starts at once.
- R10: With `data_read` = 1, payload frames drive no lane and take no transmit byte. Each payload frame yields one `rx_valid` pulse. In single-lane width, the received bit k is sampled from DQ1 on rising edge k. In dual width, bits come from DQ0..DQ1, and in quad width from DQ0..DQ3, with the same bit order as the transmit direction.
- R11: Dummy frames toggle the clock for the frame's clock count at the phase's width. They drive no lane, take no transmit byte and produce no `rx_valid`.
- R12: When a frame needs a transmit byte and `tx_valid` is low, `sck` stays low, `cs_n` stays low and no clock edge is produced until the byte arrives.
- R13: A `start` with `total_frames` = 0 is ignored: `cs_n` stays high and no clock edge occurs.
- R14: `cs_n` rises `SCK_HALF` clock cycles after the final falling edge of `sck`. It rises in the same cycle as a `done` pulse that lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transaction; taken only while idle |
| mode | input | 2 | Phase widening select: 0 all, 1 address onward, 2/3 payload only |
| lane_width | input | 2 | Wide width: 0 single, 1 dual, 2/3 quad |
| cmd_frames | input | CNT_W | Opcode frame count |
| addr_frames | input | CNT_W | Address frame count |
| dummy_frames | input | CNT_W | Dummy frame count |
| total_frames | input | LEN_W | Total frames in the transaction |
| data_read | input | 1 | Payload direction: 1 receive, 0 transmit |
| tx_data | input | FRAME_W | Outgoing frame |
| tx_valid | input | 1 | Outgoing frame offered |
| tx_ready | output | 1 | Outgoing frame accepted this cycle when valid |
| rx_data | output | FRAME_W | Received payload frame |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction strobe |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| dq_o | output | 4 | Lane output values |
| dq_oe | output | 4 | Lane output enables |
| dq_i | input | 4 | Lane input values |

## Verification
A wrong frame index or phase boundary shows at the rising edge of the first misplaced frame. `dq_oe` takes the wrong lane mask there, or the number of clocks per frame is off, so the lane trace departs from the expected one within a single frame. A wrong width register, or a shift-register slip, shows as a reordered byte on the lanes. In the read direction it shows as a wrong `rx_data` when that frame's `rx_valid` pulse arrives. A control fault at the ends of the transaction shows within a few cycles. Such faults include a chip-select break, an extra clock during a stall, a misplaced tail and a repeated done.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;

    // phases in the order a transaction runs them
    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_ADDR  = 2'd1,
        PH_DUMMY = 2'd2,
        PH_DATA  = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_LOW  = 3'd2,
        ST_HIGH = 3'd3,
        ST_TAIL = 3'd4,
        ST_DONE = 3'd5
    } state_e;

    localparam int LANES = 4;

endpackage

// File: rtl/spi_phase_track.sv
`timescale 1ns/1ps
// Maps a frame index to its phase and lane width (log2 of bits per clock).
module spi_phase_track
    import spi_seq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int LEN_W = 12
) (
    input  logic [LEN_W-1:0] fidx,
    input  logic [CNT_W-1:0] cmd_n,
    input  logic [CNT_W-1:0] addr_n,
    input  logic [CNT_W-1:0] dum_n,
    input  logic [1:0]       mode,
    input  logic [1:0]       width,
    output phase_e           phase,
    output logic [1:0]       lane_log
);
    localparam int SUM_W = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 2;

    logic [SUM_W-1:0] idx_x, cmd_end, addr_end, dum_end;
    logic             wide_phase;

    assign idx_x    = SUM_W'(fidx);
    assign cmd_end  = SUM_W'(cmd_n);
    assign addr_end = cmd_end + SUM_W'(addr_n);
    assign dum_end  = addr_end + SUM_W'(dum_n);

    always_comb begin
        if (idx_x < cmd_end)       phase = PH_CMD;
        else if (idx_x < addr_end) phase = PH_ADDR;
        else if (idx_x < dum_end)  phase = PH_DUMMY;
        else                       phase = PH_DATA;
    end

    always_comb begin
        unique case (mode)
            2'd0:    wide_phase = 1'b1;
            2'd1:    wide_phase = (phase != PH_CMD);
            default: wide_phase = (phase == PH_DATA);
        endcase
        if (!wide_phase || width == 2'd0) lane_log = 2'd0;
        else if (width == 2'd1)           lane_log = 2'd1;
        else                              lane_log = 2'd2;
    end

endmodule

// File: rtl/spi_lane_shift.sv
`timescale 1ns/1ps
// Frame shifter: LSB-first out on the low lanes, LSB-first in from the top.
// FRAME_W must be a multiple of 4.
module spi_lane_shift #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_val,
    input  logic               shift,
    input  logic               capture,
    input  logic [1:0]         lane_log,
    input  logic [3:0]         dq_i,
    output logic [3:0]         tx_lanes,
    output logic [FRAME_W-1:0] rx_word
);
    logic [FRAME_W-1:0] tx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_val;
        end else if (shift) begin
            unique case (lane_log)
                2'd0:    tx_sr <= tx_sr >> 1;
                2'd1:    tx_sr <= tx_sr >> 2;
                default: tx_sr <= tx_sr >> 4;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (capture) begin
            unique case (lane_log)
                2'd0:    rx_word <= {dq_i[1],   rx_word[FRAME_W-1:1]};
                2'd1:    rx_word <= {dq_i[1:0], rx_word[FRAME_W-1:2]};
                default: rx_word <= {dq_i[3:0], rx_word[FRAME_W-1:4]};
            endcase
        end
    end

    always_comb begin
        unique case (lane_log)
            2'd0:    tx_lanes = {3'b000, tx_sr[0]};
            2'd1:    tx_lanes = {2'b00, tx_sr[1:0]};
            default: tx_lanes = tx_sr[3:0];
        endcase
    end

    // R6: a frame is never reloaded in the cycle it advances
    assert_no_load_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !load);

endmodule

// File: rtl/spi_phase_seq.sv
`timescale 1ns/1ps
module spi_phase_seq
    import spi_seq_pkg::*;
#(
    parameter int FRAME_W  = 8,
    parameter int CNT_W    = 8,
    parameter int LEN_W    = 12,
    parameter int SCK_HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         mode,
    input  logic [1:0]         lane_width,
    input  logic [CNT_W-1:0]   cmd_frames,
    input  logic [CNT_W-1:0]   addr_frames,
    input  logic [CNT_W-1:0]   dummy_frames,
    input  logic [LEN_W-1:0]   total_frames,
    input  logic               data_read,
    input  logic [FRAME_W-1:0] tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic [FRAME_W-1:0] rx_data,
    output logic               rx_valid,
    output logic               busy,
    output logic               done,
    output logic               sck,
    output logic               cs_n,
    output logic [3:0]         dq_o,
    output logic [3:0]         dq_oe,
    input  logic [3:0]         dq_i
);
    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int CLK_W = $clog2(FRAME_W) + 1;

    state_e             state, state_nx;
    logic [DIV_W-1:0]   div_cnt;
    logic [CLK_W-1:0]   clk_cnt;
    logic [LEN_W-1:0]   fidx;
    logic [1:0]         c_mode, c_width;
    logic [CNT_W-1:0]   c_cmd, c_addr, c_dum;
    logic [LEN_W-1:0]   c_total;
    logic               c_read;
    logic [1:0]         fr_lane;
    logic               fr_drive, fr_recv;
    logic               rx_valid_q;
    phase_e             cur_phase;
    logic [1:0]         cur_lane;
    logic [3:0]         tx_lanes;
    logic               half_done, last_clk, last_frame, need_tx, go;
    logic               frame_go, frame_end, lanes_on;

    spi_phase_track #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_track (
        .fidx     (fidx),
        .cmd_n    (c_cmd),
        .addr_n   (c_addr),
        .dum_n    (c_dum),
        .mode     (c_mode),
        .width    (c_width),
        .phase    (cur_phase),
        .lane_log (cur_lane)
    );

    spi_lane_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_go),
        .load_val (need_tx ? tx_data : '0),
        .shift    (state == ST_HIGH && half_done),
        .capture  (state == ST_LOW && half_done),
        .lane_log (fr_lane),
        .dq_i     (dq_i),
        .tx_lanes (tx_lanes),
        .rx_word  (rx_data)
    );

    assign half_done  = (div_cnt == DIV_W'(SCK_HALF - 1));
    assign last_clk   = (clk_cnt == CLK_W'((FRAME_W >> fr_lane) - 1));
    assign last_frame = (({1'b0, fidx} + (LEN_W+1)'(1)) == {1'b0, c_total});
    assign need_tx    = (cur_phase == PH_CMD) || (cur_phase == PH_ADDR) ||
                        (cur_phase == PH_DATA && !c_read);
    assign go         = start && (total_frames != '0);
    assign frame_go   = (state == ST_LOAD) && (!need_tx || tx_valid);
    assign frame_end  = (state == ST_HIGH) && half_done && last_clk;

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go) state_nx = ST_LOAD;
            ST_LOAD: if (frame_go) state_nx = ST_LOW;
            ST_LOW:  if (half_done) state_nx = ST_HIGH;
            ST_HIGH: if (half_done) begin
                         if (!last_clk)       state_nx = ST_LOW;
                         else if (last_frame) state_nx = ST_TAIL;
                         else                 state_nx = ST_LOAD;
                     end
            ST_TAIL: if (half_done) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // counters, latched request, per-frame settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt    <= '0;
            clk_cnt    <= '0;
            fidx       <= '0;
            c_mode     <= '0;
            c_width    <= '0;
            c_cmd      <= '0;
            c_addr     <= '0;
            c_dum      <= '0;
            c_total    <= '0;
            c_read     <= 1'b0;
            fr_lane    <= '0;
            fr_drive   <= 1'b0;
            fr_recv    <= 1'b0;
            rx_valid_q <= 1'b0;
        end else begin
            if (state == ST_LOW || state == ST_HIGH || state == ST_TAIL)
                div_cnt <= half_done ? '0 : div_cnt + DIV_W'(1);
            else
                div_cnt <= '0;
            if (state == ST_LOAD)
                clk_cnt <= '0;
            else if (state == ST_HIGH && half_done && !last_clk)
                clk_cnt <= clk_cnt + CLK_W'(1);
            if (state == ST_IDLE && go) begin
                fidx    <= '0;
                c_mode  <= mode;
                c_width <= lane_width;
                c_cmd   <= cmd_frames;
                c_addr  <= addr_frames;
                c_dum   <= dummy_frames;
                c_total <= total_frames;
                c_read  <= data_read;
            end else if (frame_end) begin
                fidx <= fidx + LEN_W'(1);
            end
            if (frame_go) begin
                fr_lane  <= cur_lane;
                fr_drive <= need_tx;
                fr_recv  <= (cur_phase == PH_DATA) && c_read;
            end
            rx_valid_q <= frame_end && fr_recv;
        end
    end

    // outputs
    always_comb begin
        sck      = (state == ST_HIGH);
        cs_n     = (state == ST_IDLE) || (state == ST_DONE);
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
        tx_ready = (state == ST_LOAD) && need_tx;
        rx_valid = rx_valid_q;
        lanes_on = (state == ST_LOW || state == ST_HIGH) && fr_drive;
    end

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        assign dq_oe[L] = lanes_on && (L < (1 << fr_lane));
        assign dq_o[L]  = lanes_on && tx_lanes[L];
    end

    // R1: released select means a quiet link
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sck && dq_oe == 4'd0));

    // R12: an unserved byte request holds the clock low inside the frame
    assert_stall_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |=> (!sck && !cs_n));

    // R6: width of a frame cannot change while its clocks run
    assert_lane_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH) |=> $stable(fr_lane));

    // R14: done is a single-cycle strobe
    assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R14: select release coincides with done
    assert_cs_rise_done_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);

    // R10: receive strobes never come back to back
    assert_rx_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: tb/spi_phase_seq_tb.sv
`timescale 1ns/1ps
module spi_phase_seq_tb;
    localparam int SCK_HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [1:0]  lane_width = 2'd0;
    logic [7:0]  cmd_frames = 8'd0, addr_frames = 8'd0, dummy_frames = 8'd0;
    logic [11:0] total_frames = 12'd0;
    logic        data_read = 1'b0;
    logic        tx_valid = 1'b1;
    logic [7:0]  tx_data, rx_data;
    logic        tx_ready, rx_valid, busy, done, sck, cs_n;
    logic [3:0]  dq_o, dq_oe, dq_i;

    int n_checks = 0, n_fail = 0;
    int n_tx = 0, n_rx = 0, n_done = 0, cyc = 0;
    int n_edges = 0, n_csrise = 0, cyc_fall = 0, tail_len = 0;
    bit done_at_rise = 1'b0;
    int b_tx, b_rx, b_edge, b_done, b_cs;
    logic [3:0] e_oe  [0:2047];
    logic [3:0] e_dqo [0:2047];
    logic [7:0] r_byte[0:255];

    always #5 clk = ~clk;

    function automatic logic [7:0] tx_pat(int i);
        return 8'(i * 37 + 5);
    endfunction
    function automatic logic [3:0] rx_pat(int i);
        return 4'((i * 7 + 3) ^ (i >> 3));
    endfunction

    assign tx_data = tx_pat(n_tx);
    assign dq_i    = rx_pat(n_edges);

    spi_phase_seq #(.SCK_HALF(SCK_HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .lane_width(lane_width), .cmd_frames(cmd_frames),
        .addr_frames(addr_frames), .dummy_frames(dummy_frames),
        .total_frames(total_frames), .data_read(data_read),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .done(done),
        .sck(sck), .cs_n(cs_n), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
    );

    // link monitors
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tx_valid && tx_ready) n_tx <= n_tx + 1;
        if (rx_valid) begin
            r_byte[n_rx[7:0]] <= rx_data;
            n_rx <= n_rx + 1;
        end
        if (done) n_done <= n_done + 1;
    end
    always @(posedge sck) begin
        e_oe[n_edges[10:0]]  = dq_oe;
        e_dqo[n_edges[10:0]] = dq_o;
        n_edges = n_edges + 1;
    end
    always @(negedge sck) cyc_fall = cyc;
    always @(posedge cs_n) begin
        tail_len     = cyc - cyc_fall;
        done_at_rise = done;
        n_csrise     = n_csrise + 1;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    function automatic int phase_ref(int f, int c, int a, int d);
        if (f < c) return 0;
        if (f < c + a) return 1;
        if (f < c + a + d) return 2;
        return 3;
    endfunction
    function automatic int bpc_ref(int m, int w, int ph);
        bit wide;
        if (w == 0) return 1;
        wide = (m == 0) || (m == 1 && ph != 0) || (m >= 2 && ph == 3);
        if (!wide) return 1;
        return (w == 1) ? 2 : 4;
    endfunction

    task automatic txn_start(input int m, input int w, input int c, input int a,
                             input int d, input int t, input bit r);
        @(negedge clk);
        mode = 2'(m); lane_width = 2'(w);
        cmd_frames = 8'(c); addr_frames = 8'(a); dummy_frames = 8'(d);
        total_frames = 12'(t); data_read = r;
        b_tx = n_tx; b_rx = n_rx; b_edge = n_edges; b_done = n_done; b_cs = n_csrise;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic txn_finish(input int m, input int w, input int c, input int a,
                              input int d, input int t, input bit r, input string tag);
        int k = 0, p, ti, ri, bad_oe = 0, bad_tx = 0, bad_rx = 0;
        while (n_done == b_done && k < 20000) begin
            @(negedge clk);
            k++;
        end
        repeat (3) @(negedge clk);
        chk(n_done != b_done, {tag, " transaction completes"}, n_done - b_done, 1);
        p = b_edge; ti = b_tx; ri = b_rx;
        for (int f = 0; f < t; f++) begin
            int ph, bpc, cpf;
            bit drv, rcv;
            logic [7:0] tb, rb;
            ph  = phase_ref(f, c, a, d);
            bpc = bpc_ref(m, w, ph);
            cpf = 8 / bpc;
            drv = (ph < 2) || (ph == 3 && !r);
            rcv = (ph == 3) && r;
            tb = '0; rb = '0;
            for (int k2 = 0; k2 < cpf; k2++) begin
                logic [3:0] exp_oe;
                logic [3:0] din;
                exp_oe = drv ? 4'((1 << bpc) - 1) : 4'd0;
                if (e_oe[p[10:0]] !== exp_oe) bad_oe++;
                din = rx_pat(p);
                for (int j = 0; j < bpc; j++) begin
                    tb[k2 * bpc + j] = e_dqo[p[10:0]][j];
                    rb[k2 * bpc + j] = (bpc == 1) ? din[1] : din[j];
                end
                p++;
            end
            if (drv) begin
                if (tb !== tx_pat(ti)) bad_tx++;
                ti++;
            end
            if (rcv) begin
                if (r_byte[ri[7:0]] !== rb) bad_rx++;
                ri++;
            end
        end
        chk(bad_oe == 0, {tag, " R2 lane enables per frame"}, bad_oe, 0);
        chk(bad_tx == 0, {tag, " R2 transmitted frames on lanes"}, bad_tx, 0);
        chk(bad_rx == 0, {tag, " R10 received frames"}, bad_rx, 0);
        chk(n_edges - b_edge == p - b_edge, {tag, " R2 clock edge count"}, n_edges - b_edge, p - b_edge);
        chk(n_tx - b_tx == ti - b_tx, {tag, " R11 bytes consumed"}, n_tx - b_tx, ti - b_tx);
        chk(n_rx - b_rx == ri - b_rx, {tag, " R10 rx strobes"}, n_rx - b_rx, ri - b_rx);
        chk(n_done - b_done == 1, {tag, " R14 one done pulse"}, n_done - b_done, 1);
        chk(n_csrise - b_cs == 1, {tag, " R2 select released once"}, n_csrise - b_cs, 1);
        chk(tail_len == SCK_HALF, {tag, " R14 tail length"}, tail_len, SCK_HALF);
        chk(done_at_rise, {tag, " R14 done with select release"}, int'(done_at_rise), 1);
    endtask

    task automatic txn(input int m, input int w, input int c, input int a,
                       input int d, input int t, input bit r, input string tag);
        txn_start(m, w, c, a, d, t, r);
        txn_finish(m, w, c, a, d, t, r, tag);
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1 && sck == 1'b0, "R1 select high clock low", int'({cs_n, sck}), 2);
        chk(dq_oe == 4'd0, "R1 lanes released", int'(dq_oe), 0);
        chk(busy == 1'b0 && done == 1'b0, "R1 not busy", int'({busy, done}), 0);
    endtask

    task automatic t_stall();
        int e0;
        tx_valid = 1'b1;
        txn_start(1, 2, 1, 2, 1, 6, 1'b0);
        wait (n_tx - b_tx == 2);
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (20) @(negedge clk);
        e0 = n_edges;
        repeat (20) @(negedge clk);
        chk(n_edges == e0, "R12 no edges while starved", n_edges - e0, 0);
        chk(sck == 1'b0 && cs_n == 1'b0, "R12 clock low select low", int'({sck, cs_n}), 0);
        chk(n_tx - b_tx == 2, "R12 no byte taken", n_tx - b_tx, 2);
        tx_valid = 1'b1;
        txn_finish(1, 2, 1, 2, 1, 6, 1'b0, "R12 stall");
    endtask

    task automatic t_ignore();
        int e0 = n_edges;
        @(negedge clk);
        total_frames = 12'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (cs_n != 1'b1) chk(1'b0, "R13 select stayed high", int'(cs_n), 1);
        end
        chk(busy == 1'b0, "R13 empty start ignored", int'(busy), 0);
        chk(n_edges == e0, "R13 no clock edges", n_edges - e0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        txn(0, 2, 1, 3, 1, 7, 1'b0, "R3 R6 R11 all-wide quad");
        txn(1, 2, 1, 2, 1, 5, 1'b0, "R4 address-onward quad");
        txn(2, 1, 1, 2, 2, 6, 1'b0, "R5 R7 R11 payload-only dual");
        txn(3, 2, 2, 1, 1, 5, 1'b0, "R5 payload-only quad");
        txn(0, 0, 1, 1, 1, 4, 1'b0, "R8 single forced");
        txn(1, 2, 0, 0, 0, 3, 1'b0, "R9 all phases skipped");
        txn(2, 1, 2, 0, 0, 3, 1'b0, "R9 address and dummy skipped");
        txn(2, 2, 1, 1, 1, 5, 1'b1, "R10 quad read");
        txn(0, 0, 1, 0, 0, 3, 1'b1, "R10 single read");
        txn(1, 1, 1, 1, 0, 4, 1'b1, "R10 dual read");
        t_stall();
        t_ignore();
        t_reset();
        summary();
    end

endmodule